// File: doc/BRIEF.md
# Two-Step Half-Flash Conversion Sequencer

This block is the digital control for an 8-bit converter that resolves its result in two 4-bit passes. One bank of 15 comparators is shared by both passes. In the coarse pass the bank compares the analog input against the reference ladder. Its thermometer code is encoded into the upper nibble, which is latched into the result register and driven out as a DAC code. The analog side then forms the residue, which is the input minus the DAC level. After a configurable number of settle cycles the same bank is sampled again, and the encoded value becomes the lower nibble.

The block sees only digital signals. A start strobe opens a conversion and the comparator thermometer code arrives on one input. The block drives a phase select that steers the comparators between the raw input and the residue, the DAC code, the 8-bit result and a one-cycle done strobe. The encoder counts the ones in the thermometer word, so a code with a misplaced comparator still encodes to its number of tripped comparators.

Top module: `halfflash_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, result_o is 0x00, dac_code_o is 0, fine_sel_o is 0 and done_o is 0.
- R2: The clock edge after the start edge samples therm_i. At that edge the number of ones in therm_i is written to result_o[7:4] and to dac_code_o, and result_o[3:0] is cleared. This edge comes before any fine sample.
- R3: fine_sel_o is 0 while idle and during the coarse sample cycle. It is 1 from the edge that latches the upper nibble until the fine sample has been taken.
- R4: dac_code_o holds steady while fine_sel_o is 1. Exactly SETTLE_CYC cycles separate the DAC update from the fine sample, so done_o rises SETTLE_CYC+2 edges after the edge that accepts start (SETTLE_CYC must be at least 1).
- R5: The fine sample writes the ones count of therm_i to result_o[3:0] and leaves result_o[7:4] unchanged.
- R6: done_o is high for exactly one clock per conversion.
- R7: A start_i pulse that arrives while a conversion is in progress, including the done cycle, is ignored. It does not change the result, the latency or the count of done pulses.
- R8: A thermometer word with a bubble encodes to its population count. For example, 15'b000_0000_0101_1111 gives 6.
- R9: With an ideal ladder and residue, an input at the low reference gives 0x00, an input at the high reference gives 0xFF, and every input level gives its own 8-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| therm_i | input | 15 | Comparator bank thermometer code |
| dac_code_o | output | 4 | Coarse nibble to the residue DAC |
| fine_sel_o | output | 1 | 0: comparators see the input, 1: comparators see the residue |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| result_o | output | 8 | Conversion result |

## Verification
The edge that accepts start is counted as edge 0. The upper nibble and the DAC code are due after edge 1, and fine_sel_o rises after the same edge. done_o and the full result are due after edge SETTLE_CYC+2, and done_o falls one edge later. The bench drives start on a falling edge and samples only on falling edges, counting them from edge 0. It checks the phase select at count 0, the upper nibble at count 1, and the exact count at which done appears. It then checks that done has dropped on the following falling edge. The ignored-start test pulses start during the settle window and confirms that the latency is unchanged and that no second conversion follows.

// File: rtl/hf_pkg.sv
package hf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COARSE,
    ST_SETTLE,
    ST_FINE,
    ST_DONE
  } hf_state_e;
endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
  parameter int NIB_W = 4,
  localparam int THERM_W = (1 << NIB_W) - 1
) (
  input  logic [THERM_W-1:0] therm_i,
  output logic [NIB_W-1:0]   nib_o
);
  // population count: bubble-tolerant
  always_comb begin
    nib_o = '0;
    for (int i = 0; i < THERM_W; i++) begin
      nib_o = nib_o + NIB_W'(therm_i[i]);
    end
  end
endmodule

// File: rtl/hf_settle_timer.sv
module hf_settle_timer #(
  parameter int SETTLE_CYC = 2,
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(SETTLE_CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SETTLE_CYC - 1));
endmodule

// File: rtl/hf_ctrl.sv
module hf_ctrl
  import hf_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int RES_W = 2 * NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             settle_exp_i,
  output logic             settle_load_o,
  output logic [NIB_W-1:0] dac_code_o,
  output logic             fine_sel_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  hf_state_e state_q, state_d;
  logic [NIB_W-1:0] dac_q;
  logic [RES_W-1:0] res_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_COARSE;
      ST_COARSE: state_d = ST_SETTLE;
      ST_SETTLE: if (settle_exp_i) state_d = ST_FINE;
      ST_FINE:   state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dac_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_COARSE) begin
        dac_q <= nib_i;
        res_q <= {nib_i, {NIB_W{1'b0}}};
      end else if (state_q == ST_FINE) begin
        res_q[NIB_W-1:0] <= nib_i;
      end
    end
  end

  assign settle_load_o = (state_q == ST_COARSE);
  assign fine_sel_o    = (state_q == ST_SETTLE) || (state_q == ST_FINE);
  assign done_o        = (state_q == ST_DONE);
  assign dac_code_o    = dac_q;
  assign result_o      = res_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_COARSE));
  // R5
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FINE) |=> (result_o[RES_W-1:NIB_W] == $past(result_o[RES_W-1:NIB_W])));
  // R4
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_sel_o && $past(fine_sel_o)) |-> $stable(dac_code_o));
endmodule

// File: rtl/halfflash_seq.sv
module halfflash_seq #(
  parameter int NIB_W = 4,
  parameter int SETTLE_CYC = 2,
  localparam int THERM_W = (1 << NIB_W) - 1,
  localparam int RES_W = 2 * NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [THERM_W-1:0] therm_i,
  output logic [NIB_W-1:0]   dac_code_o,
  output logic               fine_sel_o,
  output logic               done_o,
  output logic [RES_W-1:0]   result_o
);
  logic [NIB_W-1:0] nib;
  logic settle_load, settle_exp;

  hf_therm_enc #(.NIB_W(NIB_W)) u_enc (
    .therm_i (therm_i),
    .nib_o   (nib)
  );

  hf_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (settle_load),
    .expired_o (settle_exp)
  );

  hf_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .nib_i         (nib),
    .settle_exp_i  (settle_exp),
    .settle_load_o (settle_load),
    .dac_code_o    (dac_code_o),
    .fine_sel_o    (fine_sel_o),
    .done_o        (done_o),
    .result_o      (result_o)
  );
endmodule

// File: tb/halfflash_seq_test.sv
`timescale 1ns/1ps
module halfflash_seq_test;
  localparam int S = 3;
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h0F, 8'hF0, 8'h5A, 8'hA5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [14:0] therm;
  logic [3:0] dac;
  logic fsel, done;
  logic [7:0] res;

  logic [7:0] lvl_in = 8'h00;
  bit ovr = 1'b0;
  logic [14:0] ovr_c = '0, ovr_f = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  halfflash_seq #(.NIB_W(4), .SETTLE_CYC(S)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .therm_i(therm),
    .dac_code_o(dac), .fine_sel_o(fsel), .done_o(done), .result_o(res)
  );

  // analog model: ladder, DAC and residue
  always_comb begin
    int lv;
    if (fsel) begin
      lv = int'(lvl_in) - 16 * int'(dac);
      if (lv < 0) lv = 0;
      if (lv > 15) lv = 15;
    end else begin
      lv = int'(lvl_in) >> 4;
    end
    if (ovr) therm = fsel ? ovr_f : ovr_c;
    else     therm = 15'((16'(1) << lv) - 16'(1));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [7:0] expv, input bit poke);
    int lat;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    chk(fsel == 1'b0, "R3 coarse phase select", int'(fsel), 0);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        chk(res == {expv[7:4], 4'h0}, "R2 upper nibble latched early", int'(res), int'({expv[7:4], 4'h0}));
        chk(fsel == 1'b1, "R3 residue phase select", int'(fsel), 1);
        if (poke) start = 1'b1;
      end else if (lat == 2 && poke) begin
        start = 1'b0;
      end
    end
    chk(lat == S + 2, "R4 done latency", lat, S + 2);
    chk(res == expv, "R5 R9 result", int'(res), int'(expv));
    chk(dac == expv[7:4], "R4 dac code", int'(dac), int'(expv[7:4]));
    if (poke) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R6 done width", int'(done), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res == 8'h00 && dac == 4'h0 && fsel == 1'b0 && done == 1'b0, "R1 in reset", int'(res), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res == 8'h00 && done == 1'b0 && fsel == 1'b0, "R1 after reset", int'(res), 0);

    // R9 vector table with ideal ladder
    for (int i = 0; i < NV; i++) begin
      lvl_in = VEC[i];
      run_conv(VEC[i], 1'b0);
    end

    // R7 start pulsed mid-conversion and in the done cycle
    lvl_in = 8'h3C;
    run_conv(8'h3C, 1'b1);
    repeat (S + 4) begin
      @(negedge clk);
      chk(done == 1'b0 && fsel == 1'b0, "R7 no restart", int'(done), 0);
    end
    chk(res == 8'h3C, "R7 result kept", int'(res), 8'h3C);

    // R8 bubbles in both passes
    ovr = 1'b1;
    ovr_c = 15'b000_0000_0101_1111;
    ovr_f = 15'b000_0001_0110_1111;
    run_conv(8'h67, 1'b0);
    ovr_c = 15'b111_1111_1111_1111;
    ovr_f = 15'b000_0000_0000_0000;
    run_conv(8'hF0, 1'b0);
    ovr = 1'b0;

    // R1 reset mid-conversion
    lvl_in = 8'hC3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(res == 8'h00 && dac == 4'h0 && fsel == 1'b0 && done == 1'b0, "R1 mid reset", int'(res), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_conv(8'hC3, 1'b0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule